// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block turns a 32-bit local transaction address into a 64-bit external address using five programmable outbound windows. Each window has five settings: a local base address, a power-of-two size of 4 KB or more, an enable, a transaction-type code and a high-order translation address. A 32-bit register port programs the windows. Software sets up the windows once, and after that every local request is looked up by the block.

On each request the block compares the local address with every enabled window. The lowest-numbered window that matches wins. The address bits below the window size pass through unchanged. The bits above them come from the window's translation address and its extended high-order field. Window 0 is also the default: a request that misses every window is translated with window 0's settings. One clock after the request, the block returns the result with the window's transaction type and the index of the window used.

Top module: `ob_xlat`

## Requirements
- R1: After reset, window 0's attribute register reads 0x8000_0000 (enabled). Every other register of every window reads zero, so windows 1 to 4 are disabled.
- R2: Window n's registers sit at 0xC00 + 0x20·n.
  - +0x00 holds translation address bits [31:12] in data bits [31:12].
  - +0x04 holds extended translation bits [43:32] in data bits [11:0].
  - +0x08 holds local base bits [31:12] in data bits [31:12].
  - +0x0C is the attribute register: enable in bit 31, transaction type in bits [11:8], size code c in bits [4:0].
  - The window size is 2^(c+12) bytes. A code of 20 or more covers the whole local space.
  - Every other data bit reads as zero.
- R3: A write to any offset not listed in R2 changes no register. A read from such an offset returns zero.
- R4: Read data appears on `cfg_rdata` after the clock edge that samples `cfg_rd`. It shows the register contents from before any write in that same cycle, and it holds until the next read.
- R5: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high.
- R6: A window hits when it is enabled and the request address agrees with its base in every bit at or above the window size. A disabled window never hits.
- R7: When several windows hit, the lowest-numbered one is used. `rsp_win` gives its index.
- R8: A request that hits no window is translated with window 0's settings. It reports `rsp_win` = 0 and window 0's transaction type.
- R9: The result address is built as follows:
  - bits [63:44] are zero;
  - bits [43:32] are the window's extended field;
  - translation bits sit at and above the window size;
  - the request address bits sit below the window size.
- R10: Base and translation bits below the window size have no effect on the hit or on the result.
- R11: A lookup requested in the same cycle as a register write uses the window settings from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_addr | output | 64 | Translated external address |
| rsp_ttype | output | 4 | Transaction type of the chosen window |
| rsp_win | output | 3 | Index of the chosen window |

## Verification
A register write and a lookup can fall in the same cycle, and the write may change the very window the lookup would use. The bench provokes this on purpose: it enables a full-space window while a request for an address inside it is issued on the same edge. It then repeats the request on the next cycle. It also drives random writes and requests together for thousands of cycles. The behavioural model applies each write only after it has evaluated that cycle's lookup and read, so the first result must come from the old settings and the next from the new.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  localparam int LA_W           = 32;
  localparam int XA_W           = 64;
  localparam int EXT_W          = 12;
  localparam int PAGE_LOG       = 12;
  localparam int PG_W           = LA_W - PAGE_LOG;
  localparam int SZ_W           = 5;
  localparam int TT_W           = 4;
  localparam int CFG_AW         = 12;
  localparam int CFG_DW         = 32;
  localparam int WIN_STRIDE_LOG = 5;
  localparam int ATTR_EN_BIT    = 31;
  localparam int ATTR_TT_LSB    = 8;
  localparam logic [CFG_AW-1:0] WIN_OFS = 12'hC00;

  typedef enum logic [1:0] {
    REG_XLAT = 2'd0,
    REG_XEXT = 2'd1,
    REG_BASE = 2'd2,
    REG_ATTR = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [SZ_W-1:0]  szc;
    logic [TT_W-1:0]  tt;
    logic [PG_W-1:0]  base;
    logic [PG_W-1:0]  xlat;
    logic [EXT_W-1:0] xext;
  } win_cfg_t;

  // Mask of the address bits that lie inside a window of size code c.
  function automatic logic [LA_W-1:0] low_mask(input logic [SZ_W-1:0] c);
    logic [LA_W-1:0] ones;
    ones = '1;
    return ~(ones << (int'(c) + PAGE_LOG));
  endfunction
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic                    cfg_rd,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [CFG_DW-1:0]       cfg_wdata,
  output logic [CFG_DW-1:0]       cfg_rdata,
  output win_cfg_t [NUM_WIN-1:0]  win_o
);
  localparam int SPAN = NUM_WIN << WIN_STRIDE_LOG;
  localparam win_cfg_t RST_W0 = '{en: 1'b1, default: '0};

  logic [CFG_AW-1:0]                rel;
  logic                             in_win;
  logic                             slot_ok;
  logic                             acc_ok;
  logic [CFG_AW-WIN_STRIDE_LOG-1:0] idx;
  reg_sel_e                         sel;
  logic [CFG_DW-1:0]                rd_d;
  logic                             unused_wbits;

  assign unused_wbits = ^cfg_wdata;

  // Offset decode shared by reads and writes
  always_comb begin
    rel     = cfg_addr - WIN_OFS;
    in_win  = (cfg_addr >= WIN_OFS) && (int'(rel) < SPAN);
    slot_ok = (rel[1:0] == 2'b00) && (rel[WIN_STRIDE_LOG-1:4] == '0);
    acc_ok  = in_win && slot_ok;
    idx     = rel[CFG_AW-1:WIN_STRIDE_LOG];
    sel     = reg_sel_e'(rel[3:2]);
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_cfg_t cur_q;
    win_cfg_t nxt_d;
    logic     we;

    assign we       = cfg_wr && acc_ok && (int'(idx) == w);
    assign win_o[w] = cur_q;

    always_comb begin
      nxt_d = cur_q;
      case (sel)
        REG_XLAT: nxt_d.xlat = cfg_wdata[LA_W-1:PAGE_LOG];
        REG_XEXT: nxt_d.xext = cfg_wdata[EXT_W-1:0];
        REG_BASE: nxt_d.base = cfg_wdata[LA_W-1:PAGE_LOG];
        default: begin
          nxt_d.en  = cfg_wdata[ATTR_EN_BIT];
          nxt_d.tt  = cfg_wdata[ATTR_TT_LSB +: TT_W];
          nxt_d.szc = cfg_wdata[SZ_W-1:0];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur_q <= (w == 0) ? RST_W0 : '0;
      else if (we) cur_q <= nxt_d;
    end
  end

  // Read mux: unused offsets and unused bits read as zero
  always_comb begin
    rd_d = '0;
    if (acc_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(idx) == w) begin
          case (sel)
            REG_XLAT: rd_d[LA_W-1:PAGE_LOG] = win_o[w].xlat;
            REG_XEXT: rd_d[EXT_W-1:0]       = win_o[w].xext;
            REG_BASE: rd_d[LA_W-1:PAGE_LOG] = win_o[w].base;
            default: begin
              rd_d[ATTR_EN_BIT]              = win_o[w].en;
              rd_d[ATTR_TT_LSB +: TT_W]      = win_o[w].tt;
              rd_d[SZ_W-1:0]                 = win_o[w].szc;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_d;
  end
endmodule

// File: rtl/ob_xlat_match.sv
module ob_xlat_match
  import ob_xlat_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [LA_W-1:0]   addr,
  output logic              hit,
  output logic [XA_W-1:0]   xaddr
);
  logic [LA_W-1:0] msk;
  logic [LA_W-1:0] base_full;
  logic [LA_W-1:0] xlat_full;
  logic            unused_tt;

  assign unused_tt = ^cfg.tt;

  always_comb begin
    msk       = low_mask(cfg.szc);
    base_full = {cfg.base, {PAGE_LOG{1'b0}}};
    xlat_full = {cfg.xlat, {PAGE_LOG{1'b0}}};
    hit       = cfg.en && (((addr ^ base_full) & ~msk) == '0);
    xaddr                 = '0;
    xaddr[LA_W +: EXT_W]  = cfg.xext;
    xaddr[LA_W-1:0]       = (xlat_full & ~msk) | (addr & msk);
  end
endmodule

// File: rtl/ob_xlat_pick.sv
module ob_xlat_pick
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_WIN-1:0]            hit,
  input  logic [NUM_WIN-1:0][XA_W-1:0]  xaddr,
  input  logic [NUM_WIN-1:0][TT_W-1:0]  tt,
  output logic [IDX_W-1:0]              win,
  output logic [XA_W-1:0]               addr,
  output logic [TT_W-1:0]               ttype
);
  // Scan downward so the lowest hitting index is kept; no hit leaves 0.
  always_comb begin
    win = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) win = IDX_W'(i);
    end
    addr  = xaddr[win];
    ttype = tt[win];
  end
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
  import ob_xlat_pkg::*;
#(
  parameter  int NUM_WIN = 5,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_addr,
  output logic              rsp_valid,
  output logic [XA_W-1:0]   rsp_addr,
  output logic [TT_W-1:0]   rsp_ttype,
  output logic [IDX_W-1:0]  rsp_win
);
  win_cfg_t [NUM_WIN-1:0]           win_cfg;
  logic [NUM_WIN-1:0]               hit;
  logic [NUM_WIN-1:0][XA_W-1:0]     xa;
  logic [NUM_WIN-1:0][TT_W-1:0]     tt;
  logic [IDX_W-1:0]                 pick_win;
  logic [XA_W-1:0]                  pick_addr;
  logic [TT_W-1:0]                  pick_tt;
  logic                             rsp_valid_d;

  ob_xlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win_o     (win_cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    ob_xlat_match u_match (
      .cfg   (win_cfg[w]),
      .addr  (req_addr),
      .hit   (hit[w]),
      .xaddr (xa[w])
    );
    assign tt[w] = win_cfg[w].tt;
  end

  ob_xlat_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .hit   (hit),
    .xaddr (xa),
    .tt    (tt),
    .win   (pick_win),
    .addr  (pick_addr),
    .ttype (pick_tt)
  );

  assign rsp_valid_d = req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_addr  <= '0;
      rsp_ttype <= '0;
      rsp_win   <= '0;
    end else if (req_valid) begin
      rsp_addr  <= pick_addr;
      rsp_ttype <= pick_tt;
      rsp_win   <= pick_win;
    end
  end
endmodule

// File: rtl/ob_xlat_chk.sv
module ob_xlat_chk
  import ob_xlat_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int IDX_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_rd,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_rdata,
  input logic              req_valid,
  input logic [LA_W-1:0]   req_addr,
  input logic              rsp_valid,
  input logic [XA_W-1:0]   rsp_addr,
  input logic [IDX_W-1:0]  rsp_win
);
  logic cfg_void;
  assign cfg_void = (int'(cfg_addr) < int'(WIN_OFS)) ||
                    (int'(cfg_addr) >= int'(WIN_OFS) + (NUM_WIN << WIN_STRIDE_LOG)) ||
                    (cfg_addr[1:0] != 2'b00) || cfg_addr[4];

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R5
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R5
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> (rsp_addr[PAGE_LOG-1:0] == $past(req_addr[PAGE_LOG-1:0]))); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_addr[XA_W-1:LA_W+EXT_W] == '0)); // R9
  AST_WIN_INDEX: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (int'(rsp_win) < NUM_WIN)); // R7
  AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n) (cfg_rd && cfg_void) |=> (cfg_rdata == '0)); // R3
endmodule

bind ob_xlat ob_xlat_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ob_xlat_tb_top.sv
module ob_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic [3:0]  rsp_ttype;
  logic [2:0]  rsp_win;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  string tag = "R1";

  // behavioural model state
  logic [31:0] m_xl[5];
  logic [31:0] m_xe[5];
  logic [31:0] m_bs[5];
  logic [31:0] m_at[5];
  logic        e_rv = 1'b0;
  logic [31:0] e_rd = '0;
  logic [63:0] e_addr = '0;
  logic [3:0]  e_tt = '0;
  logic [2:0]  e_win = '0;

  always #5 clk = ~clk;

  ob_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_ttype(rsp_ttype), .rsp_win(rsp_win)
  );

  function automatic logic [11:0] ra(input int n, input int r);
    return 12'(32'hC00 + n * 32 + r * 4);
  endfunction

  function automatic bit dec(input logic [11:0] a, output int w, output int r);
    int o;
    w = 0; r = 0;
    if (a < 12'hC00) return 0;
    o = int'(a) - 32'hC00;
    w = o / 32;
    r = (o % 32) / 4;
    if (w >= 5 || (o % 4) != 0 || (o % 32) >= 16) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] wmask(input int n);
    int s;
    s = int'(m_at[n][4:0]) + 12;
    if (s >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << s) - 32'h1;
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    int w, r;
    if (!dec(a, w, r)) return 32'h0;
    case (r)
      0: return m_xl[w];
      1: return m_xe[w];
      2: return m_bs[w];
      default: return m_at[w];
    endcase
  endfunction

  always @(posedge clk) begin
    cyc_cnt++;
    if (!rst_n) begin
      for (int n = 0; n < 5; n++) begin
        m_xl[n] = '0; m_xe[n] = '0; m_bs[n] = '0;
        m_at[n] = (n == 0) ? 32'h8000_0000 : 32'h0;
      end
      e_rv = 1'b0; e_rd = '0; e_addr = '0; e_tt = '0; e_win = '0;
    end else begin
      int w, r, hw;
      logic [31:0] mk;
      if (cfg_rd) e_rd = mread(cfg_addr);
      e_rv = req_valid;
      if (req_valid) begin
        hw = -1;
        for (int n = 0; n < 5; n++)
          if (hw < 0 && m_at[n][31] && (((req_addr ^ m_bs[n]) & ~wmask(n)) == 0)) hw = n;
        if (hw < 0) hw = 0;
        mk     = wmask(hw);
        e_addr = {20'h0, m_xe[hw][11:0], (m_xl[hw] & ~mk) | (req_addr & mk)};
        e_tt   = m_at[hw][11:8];
        e_win  = 3'(hw);
      end
      if (cfg_wr && dec(cfg_addr, w, r)) begin
        case (r)
          0: m_xl[w] = cfg_wdata & 32'hFFFF_F000;
          1: m_xe[w] = cfg_wdata & 32'h0000_0FFF;
          2: m_bs[w] = cfg_wdata & 32'hFFFF_F000;
          default: m_at[w] = cfg_wdata & 32'h8000_0F1F;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 rsp_valid", 64'(rsp_valid), 64'(e_rv));
      chk({tag, " cfg_rdata"}, 64'(cfg_rdata), 64'(e_rd));
      if (e_rv) begin
        chk({tag, " rsp_addr"}, rsp_addr, e_addr);
        chk({tag, " rsp_ttype"}, 64'(rsp_ttype), 64'(e_tt));
        chk({tag, " rsp_win"}, 64'(rsp_win), 64'(e_win));
      end
    end
  end

  always @(posedge clk) begin
    if (cyc_cnt > 100000) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", cyc_cnt, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [11:0] ca, input logic [31:0] wd,
                     input bit q, input logic [31:0] qa);
    cfg_wr = w; cfg_rd = r; cfg_addr = ca; cfg_wdata = wd;
    req_valid = q; req_addr = qa;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] ca, input logic [31:0] wd);
    cyc(1'b1, 1'b0, ca, wd, 1'b0, 32'h0);
  endtask

  task automatic rd(input logic [11:0] ca);
    cyc(1'b0, 1'b1, ca, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic rq(input logic [31:0] qa);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, qa);
  endtask

  function automatic logic [3:0] nib(input int k);
    case (k % 4)
      0: return 4'h0;
      1: return 4'h4;
      2: return 4'h6;
      default: return 4'h9;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    rd(ra(0, 3)); rd(ra(1, 3)); rd(ra(4, 0)); rd(ra(2, 2)); rq(32'h0);
    // R8: default window and its translation
    tag = "R8";
    rq(32'h1234_5678);
    wr(ra(0, 0), 32'hABCD_E123); wr(ra(0, 1), 32'hFFFF_F5A5); wr(ra(0, 3), 32'h8000_0300);
    rq(32'h7777_7ABC); rq(32'hFFFF_F001);
    // R2: field layout and unused bits
    tag = "R2";
    wr(ra(2, 3), 32'hFFFF_FFFF); rd(ra(2, 3)); wr(ra(2, 3), 32'h0);
    rd(ra(0, 0)); rd(ra(0, 1));
    wr(ra(3, 2), 32'hFFFF_FFFF); rd(ra(3, 2)); wr(ra(3, 2), 32'h0);
    // R6: hit condition, disabled window never hits
    tag = "R6";
    wr(ra(1, 2), 32'h4000_0000); wr(ra(1, 0), 32'h9000_0000); wr(ra(1, 1), 32'h0000_0123);
    rq(32'h4000_0010);
    wr(ra(1, 3), 32'h8000_0508);
    rq(32'h4000_0010); rq(32'h400F_FFFF); rq(32'h4010_0000);
    // R7: overlap priority
    tag = "R7";
    wr(ra(2, 2), 32'h4000_0000); wr(ra(2, 0), 32'h2000_0000); wr(ra(2, 3), 32'h8000_070C);
    rq(32'h4000_1000); rq(32'h4050_0000);
    wr(ra(0, 2), 32'h4000_0000); wr(ra(0, 3), 32'h8000_0304);
    rq(32'h4000_0ABC); rq(32'h4001_0000);
    wr(ra(0, 2), 32'h0);
    // R10: misaligned base and translation bits
    tag = "R10";
    wr(ra(3, 2), 32'h6001_2000); wr(ra(3, 0), 32'h7003_4000); wr(ra(3, 3), 32'h8000_0A08);
    rq(32'h6000_0044); rq(32'h600F_F000); rq(32'h6010_0000);
    // R3: unused offsets
    tag = "R3";
    wr(12'hC10, 32'hFFFF_FFFF); wr(12'hCA0, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF); wr(12'hC0E, 32'hFFFF_FFFF);
    rd(12'hC10); rd(12'hCA0); rd(12'h000); rd(12'hC0E); rd(12'hFFC);
    rq(32'h6000_0044); rd(ra(0, 3));
    // R4: read timing, read/write collision, hold
    tag = "R4";
    cyc(1'b1, 1'b1, ra(4, 0), 32'h5555_5000, 1'b0, 32'h0);
    rd(ra(4, 0)); cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0);
    wr(ra(4, 0), 32'h0);
    // R11: write and lookup in the same cycle
    tag = "R11";
    wr(ra(4, 1), 32'h0000_0FFF);
    cyc(1'b1, 1'b0, ra(4, 3), 32'h8000_0F14, 1'b1, 32'h8000_1234);
    rq(32'h8000_1234);
    // R9: full-space window passes the whole local address
    tag = "R9";
    wr(ra(4, 0), 32'hFFFF_F000);
    rq(32'hDEAD_BEEF); rq(32'h0001_0000);
    // mixed random traffic
    tag = "R6/R7/R9/R11";
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [11:0] ca;
      logic [31:0] wd, qa;
      r  = int'($urandom % 4);
      ca = ra(int'($urandom % 5), r);
      if ($urandom % 8 == 0) ca = 12'($urandom);
      wd = $urandom;
      if (r == 0 || r == 2) wd[31:28] = nib(int'($urandom));
      if (r == 3) wd[31] = ($urandom % 4 != 0);
      qa = $urandom;
      qa[31:28] = nib(int'($urandom));
      cyc($urandom % 3 == 0, $urandom % 3 == 0, ca, wd, $urandom % 2 == 0, qa);
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule